// File: doc/BRIEF.md
# Maskable Interrupt Cause Controller

This block gathers one-cycle event pulses from a set of internal sources into a sticky cause register. It then gates the pending causes through a mask register and drives a single active-low, level-sensitive interrupt line towards a management processor. Software uses a small register bus to look at both registers. It reads the cause register to see which sources are pending. It acknowledges a source by writing a zero into that source's bit of the cause register. Writing a one to a cause bit leaves that bit as it was.

The enable register uses "1 lets the source through". It comes out of reset as all zeros, so no source can disturb the processor until software enables it. Causes are recorded whether or not they are enabled. Enabling a source that is already pending therefore raises the interrupt line at once.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After synchronous reset the cause register and the enable register both hold all zeros, and `irq_n` is high.
- R2: A high level on `evt_i[i]` for one cycle sets cause bit i at the next clock edge. The bit stays set through idle cycles until software clears it.
- R3: Cause bits latch whatever the enable bits hold. A pending cause whose enable bit is 0 keeps `irq_n` high. Setting its enable bit to 1 drives `irq_n` low right after that write.
- R4: `irq_n` is low exactly while some bit position holds 1 in both the cause and the enable register. It stays low for as long as that holds, not just for one cycle.
- R5: A write to offset 0x0 clears every cause bit whose write-data bit is 0. Cause bits whose write-data bit is 1 keep their value.
- R6: When an event and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R7: The enable register sits at offset 0x4. A write there loads bit i from write-data bit i, and a read returns the written value.
- R8: Both registers are 32 bits wide, and bits at or above `NUM_SRC` read as zero. A read of any offset other than 0x0 or 0x4 returns zero. Read data appears on `bus_rdata` in the cycle after `bus_re` and is held until the next read.
- R9: A write to any offset other than 0x0 or 0x4 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_SRC | One-cycle event pulses, one per source |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write enable for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe for one cycle |
| bus_rdata | output | 32 | Read data, registered |
| irq_n | output | 1 | Combined interrupt, active low, level |

## Verification
The bench drives an event and a clearing write into the same bit in the same cycle. A design that let software win would lose that event and read back zero. The bench writes all ones to the cause register to show nothing changes; a design that treated ones as a clear, or zeros as a set, would show different read data. It enables a source that was already pending, which catches a design that only raises the line on a new event. It also writes and reads at an unused offset and with upper data bits set, which catches partial address decode and leaked upper bits.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_W = 32;

    localparam logic [REG_W-1:0] OFS_CAUSE  = 32'h0000_0000;
    localparam logic [REG_W-1:0] OFS_ENABLE = 32'h0000_0004;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_req_t;

    // Exact match on the full offset: misaligned or aliased offsets select nothing.
    function automatic reg_sel_e decode_sel(input logic [REG_W-1:0] ofs);
        if (ofs == OFS_CAUSE)  return SEL_CAUSE;
        if (ofs == OFS_ENABLE) return SEL_ENABLE;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output bus_req_t          req
);

    logic [REG_W-1:0] addr_ext;

    always_comb begin
        addr_ext = REG_W'(addr);
        req.wr   = we;
        req.rd   = re;
        req.sel  = decode_sel(addr_ext);
    end

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] cause_q
);

    logic wr_hit;

    assign wr_hit = req.wr && (req.sel == SEL_CAUSE);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic bit_q;
        logic clr_req;

        // A zero in the write data requests a clear; a one is ignored.
        assign clr_req = wr_hit && !wbits[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (evt_i[i]) begin
                bit_q <= 1'b1;          // event outranks a same-cycle clear
            end else if (clr_req) begin
                bit_q <= 1'b0;
            end
        end

        assign cause_q[i] = bit_q;
    end

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] enable_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (req.wr && (req.sel == SEL_ENABLE)) begin
            enable_q <= wbits;
        end
    end

endmodule

// File: rtl/irq_readback.sv
module irq_readback
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] cause_q,
    input  logic [NUM_SRC-1:0] enable_q,
    output logic [REG_W-1:0]   rdata
);

    logic [REG_W-1:0] rd_mux;

    always_comb begin
        unique case (req.sel)
            SEL_CAUSE:  rd_mux = REG_W'(cause_q);
            SEL_ENABLE: rd_mux = REG_W'(enable_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.rd) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_re,
    output logic [31:0]        bus_rdata,
    output logic               irq_n
);

    bus_req_t           req;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pending;
    logic               unused_wdata;

    assign wbits        = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata = ^bus_wdata;

    irq_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .we   (bus_we),
        .re   (bus_re),
        .req  (req)
    );

    irq_cause_bank #(.NUM_SRC(NUM_SRC)) u_cause (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_i),
        .req     (req),
        .wbits   (wbits),
        .cause_q (cause_q)
    );

    irq_enable_bank #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wbits    (wbits),
        .enable_q (mask_q)
    );

    irq_readback #(.NUM_SRC(NUM_SRC)) u_rdback (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cause_q  (cause_q),
        .enable_q (mask_q),
        .rdata    (bus_rdata)
    );

    assign pending = cause_q & mask_q;
    assign irq_n   = ~|pending;

endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic               bus_re,
    input logic [31:0]        bus_rdata,
    input logic               irq_n,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q
);

    localparam logic [31:0] SRC_BITS = 32'((64'd1 << NUM_SRC) - 64'd1);

    logic [31:0] a32;
    logic        wr_cause;
    logic        wr_mask;

    assign a32      = 32'(bus_addr);
    assign wr_cause = bus_we && (a32 == 32'h0);
    assign wr_mask  = bus_we && (a32 == 32'h4);

    // R2: an event pulse leaves its cause bit set one cycle later
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    // R3: with every source disabled the line stays high
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> irq_n);

    // R3: enabling a source that is already pending asserts the line
    p_unmask_pending_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && ((bus_wdata[NUM_SRC-1:0] & cause_q) != '0)) |=> !irq_n);

    // R5: a clearing write without events keeps only the one-bits
    p_clear_zeros_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_cause && (evt_i == '0)) |=>
            (cause_q == ($past(cause_q) & $past(bus_wdata[NUM_SRC-1:0]))));

    // R6: event beats a same-cycle clear
    p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_cause && (evt_i != '0)) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    // R7: an enable write loads the low data bits
    p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

    // R8: read data never carries bits above the source count
    p_rd_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> ((bus_rdata & ~SRC_BITS) == 32'h0));

    // R9: writes elsewhere and no events leave both registers unchanged
    p_other_wr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_cause && !wr_mask && (evt_i == '0)) |=> ($stable(cause_q) && $stable(mask_q)));

endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
);

// File: tb/irq_cause_ctrl_tb.sv
module irq_cause_ctrl_tb;

    localparam int NUM_SRC = 8;
    localparam int ADDR_W  = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] evt_i = '0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               bus_we = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic               bus_re = 1'b0;
    logic [31:0]        bus_rdata;
    logic               irq_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [NUM_SRC-1:0] m_cause = '0;
    logic [NUM_SRC-1:0] m_mask  = '0;

    logic [31:0] q_exp[$];
    string       q_tag[$];
    logic        re_d = 1'b0;

    always #10 clk = ~clk;

    irq_cause_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, 32'(irq_n), 32'(~|(m_cause & m_mask)));
    endtask

    // Monitor: pops the expected read data in the cycle after each strobe.
    always @(posedge clk) re_d <= bus_re;

    always @(negedge clk) begin
        if (re_d) begin
            if (q_exp.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R8 read without expectation act=0x%08h exp=none", bus_rdata);
            end else begin
                chk(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
            end
        end
    end

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [NUM_SRC-1:0] ev);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        evt_i     = ev;
        @(negedge clk);
        bus_we    = 1'b0;
        evt_i     = '0;
        if (a == 8'h00) m_cause = m_cause & d[NUM_SRC-1:0];
        if (a == 8'h04) m_mask  = d[NUM_SRC-1:0];
        m_cause = m_cause | ev;
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] ev);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
        m_cause = m_cause | ev;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cause = '0;
        m_mask  = '0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk_irq("R1 irq_n after reset");
        rd(8'h00, 32'h0, "R1 cause after reset");
        rd(8'h04, 32'h0, "R1 enable after reset");

        // R2/R3: masked events latch, line stays high
        pulse(8'h05);
        chk_irq("R3 masked pending keeps irq_n high");
        repeat (4) @(negedge clk);
        rd(8'h00, 32'h05, "R2 cause sticky after idle");

        // R3/R7: enabling a pending source asserts at once
        wr(8'h04, 32'h04, '0);
        chk("R3 unmask pending drives irq_n low", 32'(irq_n), 32'h0);
        rd(8'h04, 32'h04, "R7 enable readback");

        // R5: ones leave cause unchanged
        wr(8'h00, 32'hFFFF_FFFF, '0);
        rd(8'h00, 32'h05, "R5 write ones no effect");
        chk_irq("R5 irq_n after write ones");

        // R5/R4: clear bit 2 only
        wr(8'h00, ~32'h04, '0);
        rd(8'h00, 32'h01, "R5 clear single bit");
        chk("R4 irq_n high once enabled cause cleared", 32'(irq_n), 32'h1);

        // R8/R7: upper write bits dropped
        wr(8'h04, 32'hFFFF_FF01, '0);
        rd(8'h04, 32'h01, "R8 enable upper bits read zero");
        chk("R4 irq_n low with bit0 enabled", 32'(irq_n), 32'h0);

        // R6: event and clear in the same cycle
        wr(8'h00, 32'h0, 8'h81);
        rd(8'h00, 32'h81, "R6 event wins over clear");

        // R4: level holds for many cycles
        wr(8'h04, 32'hFF, '0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R4 irq_n level held", 32'(irq_n), 32'h0);
        end

        // R9/R8: unused offsets
        wr(8'h08, 32'h0, '0);
        wr(8'h02, 32'h0, '0);
        wr(8'h0C, 32'h0, '0);
        rd(8'h00, 32'h81, "R9 cause unchanged by other offsets");
        rd(8'h04, 32'hFF, "R9 enable unchanged by other offsets");
        rd(8'h08, 32'h0, "R8 unused offset reads zero");

        // R4/R5: clear everything
        wr(8'h00, 32'h0, '0);
        chk("R4 irq_n released after full clear", 32'(irq_n), 32'h1);
        rd(8'h00, 32'h0, "R5 cause all cleared");

        // R2: unmasked event drives line low at once
        pulse(8'h40);
        chk("R2 enabled event asserts irq_n", 32'(irq_n), 32'h0);

        // R1: reset mid-run
        do_reset();
        chk_irq("R1 irq_n after second reset");
        rd(8'h00, 32'h0, "R1 cause after second reset");
        rd(8'h04, 32'h0, "R1 enable after second reset");

        @(negedge clk);
        checks++;
        if (q_exp.size() != 0) begin
            failures++;
            $display("FAIL R8 reads missing act=%0d exp=0", q_exp.size());
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule